// File: doc/BRIEF.md
# Signalling Detect Status Byte

This block assembles an eight-bit, read-only status word that reports line signalling conditions seen by a modem receiver. Each detector is a single raw level: ring or line-polarity reversal, call-progress tone, carrier and answer tone. The block also takes a stream of received data bits with a qualifying strobe. A logic 1 in any reported bit means that the condition is present. A logic 0 means that it is absent.

A two-bit detect-select setting lets exactly one of the three tone detectors reach the status word, or none of them. A receiver-enable level gates every detect bit except the ring bit. A duration timer watches the received bits and raises a mark flag once an unbroken run of binary ones has lasted the configured number of bit periods. The default of 192 bits is 160 ms at 1200 bit/s. Three bit positions are constants, so software can recognise the word.

All reported bits are registered. Each one reflects the inputs sampled at the previous rising clock edge.

Top module: `sig_status_reg`

## Requirements
- R1: Bit 7 of `status_o` always reads 1, and bits 2 and 1 always read 0.
- R2: Bit 6 equals `ring_i` as sampled at the previous clock edge, whatever the values of `rx_en_i` and `det_sel_i`.
- R3: When `rx_en_i` is 1, the select code routes one tone detector to the status word. Code 00 routes `cpt_i` to bit 5. Code 01 routes `carrier_i` to bit 4. Code 10 routes `answer_i` to bit 3. Each of these bits follows its input one edge later.
- R4: At most one of bits 5, 4 and 3 is ever 1. A tone bit whose code is not selected reads 0. Code 11 forces all three to 0.
- R5: While `rx_en_i` is 0 at a clock edge, bits 5, 4, 3 and 0 read 0 after that edge, and the mark run count restarts.
- R6: Bit 0 becomes 1 at the edge that samples the MARK_BITS-th consecutive qualified one, with `rx_bit_valid_i` and `rx_bit_i` both 1. Cycles with `rx_bit_valid_i` at 0 neither advance nor break the run.
- R7: A qualified zero, with `rx_bit_valid_i` at 1 and `rx_bit_i` at 0, clears bit 0 at that edge and restarts the run from zero.
- R8: While `rst_ni` is low, `status_o` reads 8'h80 and the run count is cleared.
- R9: Once bit 0 is set, further qualified ones keep it set. The run count saturates and never wraps.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ring_i | input | 1 | Raw ring / polarity-reversal detector level |
| cpt_i | input | 1 | Raw call-progress tone detector level |
| carrier_i | input | 1 | Raw carrier detector level |
| answer_i | input | 1 | Raw answer-tone detector level |
| rx_bit_i | input | 1 | Received data bit |
| rx_bit_valid_i | input | 1 | Strobe qualifying `rx_bit_i` for one cycle |
| det_sel_i | input | 2 | Tone detect select: 00 call progress, 01 carrier, 10 answer, 11 none |
| rx_en_i | input | 1 | Receiver enable; gates all detect bits except ring |
| status_o | output | 8 | Status word |

## Verification
The hardest condition to reach is the exact edge at which the mark flag first rises. It depends on a long run of qualified ones, and that run can be interrupted in three ways: by a zero, by the enable dropping, or by idle strobe-less cycles that must not count. The stimulus counts the bits it feeds in. It checks bit 0 both one bit short of the limit and at the limit. It inserts idle gaps in the middle of a run and expects the rise to be neither delayed nor advanced. It then breaks the run with a zero and with a disable, and counts the full run again each time. The gating logic is swept over every combination of the four detector levels, the select code and the enable.

// File: rtl/sig_status_pkg.sv
package sig_status_pkg;

  typedef enum logic [1:0] {
    SEL_CPT  = 2'b00,
    SEL_CAR  = 2'b01,
    SEL_ANS  = 2'b10,
    SEL_NONE = 2'b11
  } det_sel_e;

  localparam int unsigned NUM_TONES = 3;

  // tone index i lands on status bit TONE_LSB + i; index 2 is call progress
  localparam int unsigned TONE_LSB  = 3;
  localparam int unsigned RING_BIT  = 6;
  localparam int unsigned FIXED_BIT = 7;
  localparam int unsigned MARK_BIT  = 0;

  function automatic logic [1:0] tone_code(input int unsigned idx);
    return 2'(NUM_TONES - 1 - idx);
  endfunction

endpackage

// File: rtl/sig_tone_gate.sv
module sig_tone_gate
  import sig_status_pkg::*;
(
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [NUM_TONES-1:0] tone_raw_i,
  input  logic [1:0]           det_sel_i,
  input  logic                 rx_en_i,
  output logic [NUM_TONES-1:0] tone_o
);

  logic [NUM_TONES-1:0] tone_d;

  for (genvar i = 0; i < NUM_TONES; i++) begin : g_tone
    localparam logic [1:0] CODE = tone_code(i);
    assign tone_d[i] = rx_en_i && (det_sel_i == CODE) && tone_raw_i[i];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) tone_o <= '0;
    else         tone_o <= tone_d;
  end

endmodule

// File: rtl/sig_mark_timer.sv
module sig_mark_timer #(
  parameter int unsigned MARK_BITS = 192
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  logic bit_i,
  input  logic valid_i,
  output logic mark_o
);

  localparam int unsigned CNT_W = $clog2(MARK_BITS + 1);
  localparam logic [CNT_W-1:0] LIMIT = CNT_W'(MARK_BITS);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)           cnt_q <= '0;
    else if (!en_i)        cnt_q <= '0;
    else if (valid_i) begin
      if (!bit_i)          cnt_q <= '0;
      else if (cnt_q != LIMIT) cnt_q <= cnt_q + CNT_W'(1);
    end
  end

  assign mark_o = (cnt_q == LIMIT);

endmodule

// File: rtl/sig_status_reg.sv
module sig_status_reg
  import sig_status_pkg::*;
#(
  parameter int unsigned MARK_BITS = 192
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       ring_i,
  input  logic       cpt_i,
  input  logic       carrier_i,
  input  logic       answer_i,
  input  logic       rx_bit_i,
  input  logic       rx_bit_valid_i,
  input  logic [1:0] det_sel_i,
  input  logic       rx_en_i,
  output logic [7:0] status_o
);

  logic                 ring_q;
  logic [NUM_TONES-1:0] tone_q;
  logic                 mark;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ring_q <= 1'b0;
    else         ring_q <= ring_i;
  end

  sig_tone_gate u_gate (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .tone_raw_i ({cpt_i, carrier_i, answer_i}),
    .det_sel_i  (det_sel_i),
    .rx_en_i    (rx_en_i),
    .tone_o     (tone_q)
  );

  sig_mark_timer #(.MARK_BITS(MARK_BITS)) u_mark (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .en_i    (rx_en_i),
    .bit_i   (rx_bit_i),
    .valid_i (rx_bit_valid_i),
    .mark_o  (mark)
  );

  always_comb begin
    status_o                                 = '0;
    status_o[FIXED_BIT]                      = 1'b1;
    status_o[RING_BIT]                       = ring_q;
    status_o[TONE_LSB +: NUM_TONES]          = tone_q;
    status_o[MARK_BIT]                       = mark;
  end

endmodule

// File: rtl/sig_status_chk.sv
module sig_status_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       ring_i,
  input logic       rx_bit_i,
  input logic       rx_bit_valid_i,
  input logic [1:0] det_sel_i,
  input logic       rx_en_i,
  input logic [7:0] status_o
);

  a_r1_fixed_bits: assert property (@(posedge clk_i) disable iff (!rst_ni)
    status_o[7] && (status_o[2:1] == 2'b00));

  a_r2_ring_follow: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> status_o[6] == $past(ring_i));

  a_r4_exclusive: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(status_o[5:3]));

  a_r4_none_sel: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (det_sel_i == 2'b11) |=> status_o[5:3] == 3'b000);

  a_r5_disable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rx_en_i |=> (status_o[5:3] == 3'b000) && !status_o[0]);

  a_r7_zero_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rx_en_i && rx_bit_valid_i && !rx_bit_i) |=> !status_o[0]);

  a_r6_rise_on_one: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(status_o[0]) |-> $past(rx_en_i && rx_bit_valid_i && rx_bit_i));

  a_r9_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (status_o[0] && rx_en_i && !(rx_bit_valid_i && !rx_bit_i)) |=> status_o[0]);

endmodule

bind sig_status_reg sig_status_chk u_chk (
  .clk_i          (clk_i),
  .rst_ni         (rst_ni),
  .ring_i         (ring_i),
  .rx_bit_i       (rx_bit_i),
  .rx_bit_valid_i (rx_bit_valid_i),
  .det_sel_i      (det_sel_i),
  .rx_en_i        (rx_en_i),
  .status_o       (status_o)
);

// File: tb/sig_status_reg_test.sv
module sig_status_reg_test;

  localparam int unsigned MARK_BITS = 192;

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       ring_i = 1'b0, cpt_i = 1'b0, carrier_i = 1'b0, answer_i = 1'b0;
  logic       rx_bit_i = 1'b0, rx_bit_valid_i = 1'b0, rx_en_i = 1'b0;
  logic [1:0] det_sel_i = 2'b00;
  logic [7:0] status_o;

  int n_run = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #2 clk_i = ~clk_i;

  sig_status_reg #(.MARK_BITS(MARK_BITS)) uut (
    .clk_i, .rst_ni, .ring_i, .cpt_i, .carrier_i, .answer_i,
    .rx_bit_i, .rx_bit_valid_i, .det_sel_i, .rx_en_i, .status_o
  );

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk_i);
  endtask

  task automatic push(input logic v, input logic b);
    rx_bit_valid_i = v;
    rx_bit_i = b;
    step();
  endtask

  initial begin
    #1_000_000;
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    logic [2:0] exp_t;
    // R8 reset value
    step(); step();
    check("R8 reset", status_o, 8'h80);
    rst_ni = 1'b1;
    step();

    // R1..R5 sweep
    for (int c = 0; c < 128; c++) begin
      {ring_i, cpt_i, carrier_i, answer_i, rx_en_i, det_sel_i} = 7'(c);
      step();
      exp_t = 3'b000;
      if (rx_en_i) begin
        case (det_sel_i)
          2'b00: exp_t = {cpt_i, 2'b00};
          2'b01: exp_t = {1'b0, carrier_i, 1'b0};
          2'b10: exp_t = {2'b00, answer_i};
          default: exp_t = 3'b000;
        endcase
      end
      check("R1 fixed", {status_o[7], 4'b0, status_o[2:1], 1'b0}, 8'h80);
      check("R2 ring", {7'b0, status_o[6]}, {7'b0, ring_i});
      if (!rx_en_i) check("R5 gated", {5'b0, status_o[5:3]}, 8'h00);
      else if (det_sel_i == 2'b11) check("R4 none", {5'b0, status_o[5:3]}, 8'h00);
      else check("R3 R4 tones", {5'b0, status_o[5:3]}, {5'b0, exp_t});
    end

    // mark timer
    {ring_i, cpt_i, carrier_i, answer_i} = 4'b0;
    det_sel_i = 2'b11;
    rx_en_i = 1'b1;
    push(1'b1, 1'b0);
    for (int k = 0; k < MARK_BITS - 1; k++) begin
      push(1'b1, 1'b1);
      if (k % 37 == 0) push(1'b0, 1'b0); // idle gap, must not break run
    end
    check("R6 one short", {7'b0, status_o[0]}, 8'h00);
    push(1'b0, 1'b1);
    check("R6 idle no count", {7'b0, status_o[0]}, 8'h00);
    push(1'b1, 1'b1);
    check("R6 at limit", {7'b0, status_o[0]}, 8'h01);
    for (int k = 0; k < 20; k++) push(1'b1, 1'b1);
    check("R9 saturate hold", {7'b0, status_o[0]}, 8'h01);
    push(1'b0, 1'b0);
    check("R9 idle hold", {7'b0, status_o[0]}, 8'h01);
    push(1'b1, 1'b0);
    check("R7 zero clears", {7'b0, status_o[0]}, 8'h00);
    for (int k = 0; k < MARK_BITS - 1; k++) push(1'b1, 1'b1);
    check("R7 restart short", {7'b0, status_o[0]}, 8'h00);
    push(1'b1, 1'b1);
    check("R7 restart full", {7'b0, status_o[0]}, 8'h01);
    rx_en_i = 1'b0;
    push(1'b1, 1'b1);
    check("R5 disable mark", {7'b0, status_o[0]}, 8'h00);
    rx_en_i = 1'b1;
    for (int k = 0; k < MARK_BITS - 1; k++) push(1'b1, 1'b1);
    check("R5 run restarted", {7'b0, status_o[0]}, 8'h00);
    push(1'b1, 1'b1);
    check("R5 run full", {7'b0, status_o[0]}, 8'h01);
    check("R1 with mark", status_o, 8'h81);

    // R8 asynchronous reset clears count
    #1 rst_ni = 1'b0;
    #1 check("R8 async", status_o, 8'h80);
    step();
    rst_ni = 1'b1;
    push(1'b1, 1'b1);
    check("R8 count cleared", {7'b0, status_o[0]}, 8'h00);

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule